// File: doc/BRIEF.md
# Performance Level Index Controller

This block turns a software performance request, written as a percentage of full performance, into one of a small set of operating-point indices. Software programs the request over an APB slave port. The block quantizes the request onto fixed per-level percentage thresholds. It then drives the selected index as a thermometer code to a clock generator and to a voltage controller.

Three sources can set the target. A test override input has the highest priority. A hardware maximum-performance request comes next, and the software request is last. A debug mode holds the voltage target at the top level while the clock target still follows the request. The clock generator and the voltage controller each report their current level as a thermometer code from their own clock domain. The block synchronizes each of these codes, accepts a code only once it is stable, and shows the accepted index in a status register.

Top module: `perf_index_ctrl`

## Requirements
- R1: The APB port has no wait states and never signals an error (pready=1, pslverr=0). The request register is at offset 0x00, holds bits [7:0] and resets to 0.
- R2: The selected level is the lowest index k whose threshold floor((k+1)*100/NUM_LVL) is greater than or equal to the request. With 8 levels the thresholds are 12,25,37,50,62,75,87,100. Any request above 100 selects the top level.
- R3: Each target output carries index k as a thermometer code with bits [k-1:0] set and the rest clear. The outputs take a new value on the clock edge after the edge that completes the APB write.
- R4: While max_req is high and test_en is low, both targets show the top level from the next edge on. When max_req falls, the software target returns on the next edge.
- R5: max_ack equals max_req delayed by one clock edge.
- R6: While test_en is high, both targets show test_idx, clamped to the top level, from the next edge on. This holds whatever max_req, debug mode or the request are.
- R7: Control register 0x04 bit 0 turns on debug mode. In debug mode, with test_en low, the voltage target shows the top level and the clock target follows the software or maximum-performance selection.
- R8: The read-only registers are: 0x0C the number of levels, 0x10 the processor clock in kHz, 0x14 the controller clock in kHz, and 0x20+4k the threshold of level k.
- R9: The status register 0x08 has these fields: [1:0] the active source (0 software, 1 maximum request, 2 test), [2] max_ack, [7:4] the current target index, [11:8] the accepted clock level index and [15:12] the accepted voltage level index.
- R10: Each returned level code passes through two synchronizing flops. It is accepted only when two consecutive synchronized samples agree, so a code that changes on every cycle never replaces the accepted value. An input that stays stable for 4 clock edges is accepted.
- R11: A write to an undefined offset changes no register and no output. A read from an undefined offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always zero |
| max_req | input | 1 | Hardware maximum-performance request |
| max_ack | output | 1 | Acknowledge of the maximum request |
| test_en | input | 1 | Test override enable |
| test_idx | input | 3 | Index applied in test override |
| clk_tgt_therm | output | 7 | Clock generator target, thermometer code |
| volt_tgt_therm | output | 7 | Voltage controller target, thermometer code |
| clk_cur_therm | input | 7 | Current clock level, asynchronous |
| volt_cur_therm | input | 7 | Current voltage level, asynchronous |

## Verification
A wrong quantizer result or a wrong priority decision shows at the target thermometer outputs one edge after its cause, and the status source field shows it at the same time. A broken synchronizer or stability filter shows in the status level fields: either the value arrives early, before the fourth edge, or a code that toggles on every cycle gets through. A corrupted register decode shows on the next read of the request or threshold registers, or one edge later at the target outputs.

// File: rtl/pic_pkg.sv
// Shared types, register offsets and level helpers for the performance
// level index controller. Assumes at most 16 levels (4-bit index fields).
package pic_pkg;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_MAX  = 2'd1,
        SRC_TEST = 2'd2
    } src_e;

    localparam logic [7:0] OFS_REQ    = 8'h00;
    localparam logic [7:0] OFS_CTRL   = 8'h04;
    localparam logic [7:0] OFS_STAT   = 8'h08;
    localparam logic [7:0] OFS_NLVL   = 8'h0C;
    localparam logic [7:0] OFS_CPUKHZ = 8'h10;
    localparam logic [7:0] OFS_CTLKHZ = 8'h14;
    localparam logic [7:0] OFS_THR    = 8'h20;

    // Percentage threshold of level k out of n levels.
    function automatic int unsigned lvl_thresh(input int unsigned k, input int unsigned n);
        return ((k + 1) * 100) / n;
    endfunction

endpackage

// File: rtl/pic_apb_regs.sv
// APB register file: request, control, status and read-only info.
// Assumes zero-wait APB; writes are committed at the access-phase edge.
module pic_apb_regs
    import pic_pkg::*;
#(
    parameter int unsigned NUM_LVL  = 8,
    parameter int unsigned CPU_KHZ  = 400000,
    parameter int unsigned CTRL_KHZ = 100000,
    localparam int unsigned IW      = $clog2(NUM_LVL)
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [7:0]    paddr,
    input  logic [31:0]   pwdata,
    output logic [31:0]   prdata,
    output logic [7:0]    req_pct,
    output logic          dbg_en,
    input  src_e          src,
    input  logic          max_ack,
    input  logic [IW-1:0] tgt_idx,
    input  logic [IW-1:0] clk_idx,
    input  logic [IW-1:0] volt_idx
);

    logic wr_en;
    assign wr_en = psel && penable && pwrite;

    // Commit writes to defined writable registers only.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            req_pct <= '0;
            dbg_en  <= 1'b0;
        end else if (wr_en) begin
            if (paddr == OFS_REQ)  req_pct <= pwdata[7:0];
            if (paddr == OFS_CTRL) dbg_en  <= pwdata[0];
        end
    end

    // Read data multiplexer; undefined offsets return zero.
    always_comb begin
        prdata = '0;
        case (paddr)
            OFS_REQ:    prdata = {24'd0, req_pct};
            OFS_CTRL:   prdata = {31'd0, dbg_en};
            OFS_STAT:   prdata = {16'd0, 4'(volt_idx), 4'(clk_idx), 4'(tgt_idx),
                                  1'b0, max_ack, src};
            OFS_NLVL:   prdata = 32'(NUM_LVL);
            OFS_CPUKHZ: prdata = 32'(CPU_KHZ);
            OFS_CTLKHZ: prdata = 32'(CTRL_KHZ);
            default: begin
                for (int k = 0; k < int'(NUM_LVL); k++) begin
                    if (paddr == OFS_THR + 8'(4 * k))
                        prdata = 32'(lvl_thresh(k, NUM_LVL));
                end
            end
        endcase
    end

endmodule

// File: rtl/pic_quantizer.sv
// Maps a percentage request onto the lowest level whose threshold covers it.
// Purely combinational; requests above every threshold select the top level.
module pic_quantizer
    import pic_pkg::*;
#(
    parameter int unsigned NUM_LVL = 8,
    localparam int unsigned IW     = $clog2(NUM_LVL)
) (
    input  logic [7:0]    req_pct,
    output logic [IW-1:0] idx
);

    // Scan from the top down so the lowest matching level wins.
    always_comb begin
        idx = IW'(NUM_LVL - 1);
        for (int k = int'(NUM_LVL) - 1; k >= 0; k--) begin
            if (32'(req_pct) <= lvl_thresh(k, NUM_LVL))
                idx = IW'(k);
        end
    end

endmodule

// File: rtl/pic_therm_sync.sv
// Brings an asynchronous thermometer level into pclk: two synchronizing
// flops, then acceptance only when two successive samples agree.
// Assumes the source changes its code one bit at a time.
module pic_therm_sync #(
    parameter int unsigned NUM_LVL = 8,
    localparam int unsigned TW     = NUM_LVL - 1,
    localparam int unsigned IW     = $clog2(NUM_LVL)
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic [TW-1:0] therm_async,
    output logic [IW-1:0] lvl_idx
);

    logic [TW-1:0] s1_q, s2_q, s3_q, acc_q;

    // Synchronizer chain with a stability filter on its output.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            s1_q  <= '0;
            s2_q  <= '0;
            s3_q  <= '0;
            acc_q <= '0;
        end else begin
            s1_q <= therm_async;
            s2_q <= s1_q;
            s3_q <= s2_q;
            if (s2_q == s3_q) acc_q <= s2_q;
        end
    end

    assign lvl_idx = IW'($countones(acc_q));

endmodule

// File: rtl/perf_index_ctrl.sv
// Top of the performance level index controller. Chooses between test,
// maximum-request and software sources, registers thermometer targets and
// reports synchronized returned levels. Assumes max_req and test inputs are
// synchronous to pclk.
module perf_index_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned NUM_LVL  = 8,
    parameter int unsigned CPU_KHZ  = 400000,
    parameter int unsigned CTRL_KHZ = 100000,
    localparam int unsigned TW      = NUM_LVL - 1,
    localparam int unsigned IW      = $clog2(NUM_LVL),
    localparam logic [IW-1:0] TOP   = IW'(NUM_LVL - 1)
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [7:0]    paddr,
    input  logic [31:0]   pwdata,
    output logic [31:0]   prdata,
    output logic          pready,
    output logic          pslverr,
    input  logic          max_req,
    output logic          max_ack,
    input  logic          test_en,
    input  logic [IW-1:0] test_idx,
    output logic [TW-1:0] clk_tgt_therm,
    output logic [TW-1:0] volt_tgt_therm,
    input  logic [TW-1:0] clk_cur_therm,
    input  logic [TW-1:0] volt_cur_therm
);

    logic [7:0]    req_pct;
    logic          dbg_en;
    logic [IW-1:0] q_idx, clk_sel, volt_sel, test_cl, tgt_idx_q;
    logic [IW-1:0] clk_lvl, volt_lvl;
    src_e          src_d, src_q;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    pic_apb_regs #(.NUM_LVL(NUM_LVL), .CPU_KHZ(CPU_KHZ), .CTRL_KHZ(CTRL_KHZ)) regs_i (
        .pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
        .req_pct, .dbg_en, .src(src_q), .max_ack, .tgt_idx(tgt_idx_q),
        .clk_idx(clk_lvl), .volt_idx(volt_lvl)
    );

    pic_quantizer #(.NUM_LVL(NUM_LVL)) quant_i (.req_pct, .idx(q_idx));

    pic_therm_sync #(.NUM_LVL(NUM_LVL)) clk_sync_i (
        .pclk, .presetn, .therm_async(clk_cur_therm), .lvl_idx(clk_lvl));

    pic_therm_sync #(.NUM_LVL(NUM_LVL)) volt_sync_i (
        .pclk, .presetn, .therm_async(volt_cur_therm), .lvl_idx(volt_lvl));

    assign test_cl = (test_idx > TOP) ? TOP : test_idx;

    // Priority selection: test, then maximum request, then software.
    always_comb begin
        if (test_en) begin
            src_d    = SRC_TEST;
            clk_sel  = test_cl;
            volt_sel = test_cl;
        end else if (max_req) begin
            src_d    = SRC_MAX;
            clk_sel  = TOP;
            volt_sel = TOP;
        end else begin
            src_d    = SRC_SW;
            clk_sel  = q_idx;
            volt_sel = dbg_en ? TOP : q_idx;
        end
    end

    // Register source, acknowledge and target index.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            src_q     <= SRC_SW;
            max_ack   <= 1'b0;
            tgt_idx_q <= '0;
        end else begin
            src_q     <= src_d;
            max_ack   <= max_req;
            tgt_idx_q <= clk_sel;
        end
    end

    // Thermometer encoders, one flop per output bit.
    for (genvar b = 0; b < TW; b++) begin : g_therm
        always_ff @(posedge pclk) begin
            if (!presetn) begin
                clk_tgt_therm[b]  <= 1'b0;
                volt_tgt_therm[b] <= 1'b0;
            end else begin
                clk_tgt_therm[b]  <= (int'(clk_sel) > b);
                volt_tgt_therm[b] <= (int'(volt_sel) > b);
            end
        end
    end

endmodule

// File: rtl/perf_index_ctrl_chk.sv
// Assertion checker for perf_index_ctrl, attached by bind.
module perf_index_ctrl_chk #(
    parameter int unsigned NUM_LVL = 8,
    localparam int unsigned TW     = NUM_LVL - 1,
    localparam int unsigned IW     = $clog2(NUM_LVL)
) (
    input logic          pclk,
    input logic          presetn,
    input logic          pready,
    input logic          pslverr,
    input logic          max_req,
    input logic          max_ack,
    input logic          test_en,
    input logic [IW-1:0] test_idx,
    input logic          dbg_en,
    input logic [TW-1:0] clk_tgt_therm,
    input logic [TW-1:0] volt_tgt_therm
);

    function automatic logic [TW-1:0] th(input logic [IW-1:0] k);
        logic [TW-1:0] r;
        for (int b = 0; b < int'(TW); b++) r[b] = (b < int'(k));
        return (int'(k) > int'(TW)) ? '1 : r;
    endfunction

    p_apb_ready_r1: assert property (@(posedge pclk) disable iff (!presetn)
        pready && !pslverr);

    p_therm_shape_r3: assert property (@(posedge pclk) disable iff (!presetn)
        (((clk_tgt_therm + 1'b1) & clk_tgt_therm) == '0) &&
        (((volt_tgt_therm + 1'b1) & volt_tgt_therm) == '0));

    p_max_top_r4: assert property (@(posedge pclk) disable iff (!presetn)
        (max_req && !test_en) |=> (clk_tgt_therm == '1) && (volt_tgt_therm == '1));

    p_ack_delay_r5: assert property (@(posedge pclk) disable iff (!presetn)
        1'b1 |=> (max_ack == $past(max_req)));

    p_test_wins_r6: assert property (@(posedge pclk) disable iff (!presetn)
        test_en |=> (clk_tgt_therm == th($past(test_idx))) &&
                    (volt_tgt_therm == th($past(test_idx))));

    p_debug_volt_r7: assert property (@(posedge pclk) disable iff (!presetn)
        (dbg_en && !test_en) |=> (volt_tgt_therm == '1));

endmodule

bind perf_index_ctrl perf_index_ctrl_chk #(.NUM_LVL(NUM_LVL)) chk_i (.*);

// File: tb/perf_index_ctrl_tb_top.sv
`timescale 1ns/1ps
module perf_index_ctrl_tb_top;

    localparam int NL = 8;
    localparam int TW = NL - 1;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        max_req = 0, max_ack;
    logic        test_en = 0;
    logic [2:0]  test_idx = '0;
    logic [TW-1:0] clk_tgt_therm, volt_tgt_therm;
    logic [TW-1:0] clk_cur_therm = '0, volt_cur_therm = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rd;

    always #2.5 pclk = ~pclk;

    perf_index_ctrl dut_i (.*);

    // Request percentage and expected level index.
    localparam logic [15:0] VEC [11] = '{
        {8'd0,   8'd0}, {8'd12,  8'd0}, {8'd13, 8'd1}, {8'd25, 8'd1},
        {8'd26,  8'd2}, {8'd50,  8'd3}, {8'd51, 8'd4}, {8'd87, 8'd6},
        {8'd88,  8'd7}, {8'd100, 8'd7}, {8'd200, 8'd7}
    };

    function automatic logic [31:0] th(input int k);
        return (32'd1 << k) - 32'd1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        d = prdata;
        psel = 0; penable = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge pclk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1;
        @(negedge pclk);
        // Reset state (R1, R3)
        check("R3 reset clk target", 32'(clk_tgt_therm), 0);
        check("R3 reset volt target", 32'(volt_tgt_therm), 0);
        check("R5 reset ack", 32'(max_ack), 0);
        check("R1 pready", 32'({pready, pslverr}), 32'b10);
        apb_rd(8'h00, rd); check("R1 request reset value", rd, 0);

        // Quantization table (R2, R3)
        for (int i = 0; i < 11; i++) begin
            apb_wr(8'h00, 32'(VEC[i][15:8]));
            @(negedge pclk);
            check("R2 clk target", 32'(clk_tgt_therm), th(int'(VEC[i][7:0])));
            check("R3 volt target", 32'(volt_tgt_therm), th(int'(VEC[i][7:0])));
        end
        apb_rd(8'h00, rd); check("R1 request readback", rd, 200);

        // Info registers (R8)
        apb_rd(8'h0C, rd); check("R8 level count", rd, 8);
        apb_rd(8'h10, rd); check("R8 cpu kHz", rd, 400000);
        apb_rd(8'h14, rd); check("R8 ctrl kHz", rd, 100000);
        apb_rd(8'h2C, rd); check("R8 threshold 3", rd, 50);
        apb_rd(8'h3C, rd); check("R8 threshold 7", rd, 100);

        // Maximum request (R4, R5, R9)
        apb_wr(8'h00, 25);
        @(negedge pclk);
        max_req = 1;
        @(negedge pclk);
        check("R4 max clk", 32'(clk_tgt_therm), th(7));
        check("R5 ack rises", 32'(max_ack), 1);
        apb_rd(8'h08, rd);
        check("R9 source max", 32'(rd[1:0]), 1);
        check("R9 ack bit", 32'(rd[2]), 1);
        check("R9 target idx", 32'(rd[7:4]), 7);

        // Test override beats max request (R6)
        test_en = 1; test_idx = 3'd2;
        @(negedge pclk);
        check("R6 test clk", 32'(clk_tgt_therm), th(2));
        check("R6 test volt", 32'(volt_tgt_therm), th(2));
        apb_rd(8'h08, rd); check("R9 source test", 32'(rd[1:0]), 2);
        test_en = 0; max_req = 0;
        @(negedge pclk);
        check("R4 release clk", 32'(clk_tgt_therm), th(1));
        check("R5 ack falls", 32'(max_ack), 0);

        // Debug mode (R7)
        apb_wr(8'h04, 1);
        @(negedge pclk);
        check("R7 debug clk", 32'(clk_tgt_therm), th(1));
        check("R7 debug volt", 32'(volt_tgt_therm), th(7));
        apb_wr(8'h04, 0);
        @(negedge pclk);
        check("R7 debug off volt", 32'(volt_tgt_therm), th(1));

        // Undefined write ignored (R11)
        apb_wr(8'h7C, 32'h0000_0063);
        @(negedge pclk);
        apb_rd(8'h00, rd); check("R11 request unchanged", rd, 25);
        apb_rd(8'h04, rd); check("R11 control unchanged", rd, 0);
        check("R11 target unchanged", 32'(clk_tgt_therm), th(1));
        apb_rd(8'h7C, rd); check("R11 undefined read", rd, 0);

        // Returned level sync (R10)
        clk_cur_therm = th(5)[TW-1:0];
        volt_cur_therm = th(3)[TW-1:0];
        apb_rd(8'h08, rd); check("R10 not yet accepted", 32'(rd[11:8]), 0);
        repeat (4) @(negedge pclk);
        apb_rd(8'h08, rd);
        check("R10 clk level", 32'(rd[11:8]), 5);
        check("R10 volt level", 32'(rd[15:12]), 3);
        for (int i = 0; i < 10; i++) begin
            @(negedge pclk);
            clk_cur_therm = (i % 2 == 0) ? th(2)[TW-1:0] : th(3)[TW-1:0];
        end
        @(negedge pclk);
        clk_cur_therm = th(5)[TW-1:0];
        @(negedge pclk);
        apb_rd(8'h08, rd); check("R10 toggling rejected", 32'(rd[11:8]), 5);

        finish_run();
    end

endmodule